// File: doc/BRIEF.md
# Configurable UART Frame Receiver

This block turns an asynchronous serial line into received characters. It brings the line into the clock domain through a short synchronizer and waits for a high-to-low transition. It then confirms the start bit at its midpoint and samples every later bit at its own midpoint. The bit timing comes from an external strobe, `tick`, that pulses sixteen times per bit period. The character format is set by static configuration inputs: character length, an optional extra bit, an optional parity bit of four kinds, and a short or long stop field.

Each character ends when its last checked stop bit is sampled. At that point the block reports a parity error flag and a framing error flag. When the frame qualifies, it also gives a one-cycle completion pulse together with the received data and extra bit. A qualifying frame has all checked stop bits high and, in multiprocessor addressing mode, a high extra bit. The extra-bit condition lets a node ignore data frames and wake only on address frames. Address filtering is switched off whenever parity is enabled.

Top module: `uart_frame_rx`

## Requirements
- R1: The line passes through a two-stage synchronizer. In idle, a high-to-low transition of the synchronized line starts a frame. On the 8th tick after that, the start bit is sampled: if it is high, the frame is abandoned with no output change, and if it is low, the following bits are sampled every 16 ticks after it.
- R2: `cfgLen` selects the data length: 2'b00=5, 2'b01=6, 2'b10=7, 2'b11=8 bits. Data arrives LSB first and `rxData` holds it right-aligned, with the unused upper bits zero.
- R3: The bit order after the data is: extra bit (when `cfgExtraEn`=1), then parity bit (when `cfgParEn`=1), then the stop field. `rxExtra` gives the received extra bit, or 0 when the extra bit is disabled.
- R4: The parity bit covers the data bits only. `cfgParType` selects the kind: 2'b00 odd (the data ones plus the parity bit make an odd total), 2'b01 even, 2'b10 always 1, 2'b11 always 0. `parityErr` is 1 only when parity is enabled and the received bit differs from the expected one.
- R5: With `cfgLongStop`=0, one stop bit is checked. With `cfgLongStop`=1 and 6 to 8 data bits, two stop bits are checked. With `cfgLongStop`=1 and 5 data bits, one stop bit is checked and the following half bit is not. A falling edge before that half bit ends does not start a frame.
- R6: `frameErr` is 1 when any checked stop bit was sampled low. Such a frame gives no `rxDone`.
- R7: With `cfgMultiProc`=1 and `cfgParEn`=0, a frame completes only if its extra bit is 1. With the extra bit disabled, no frame completes in this mode.
- R8: With `cfgParEn`=1, `cfgMultiProc` has no effect.
- R9: `parityErr` and `frameErr` are updated at the clock edge that samples the last checked stop bit of every frame, and hold until the next frame. `rxData` and `rxExtra` change only with `rxDone`. `rxDone` lasts one cycle and goes high on that same edge.
- R10: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Oversample strobe, 16 per bit period |
| rxIn | input | 1 | Serial line, idle high |
| cfgLen | input | 2 | Data length select |
| cfgParEn | input | 1 | Parity bit present and checked |
| cfgParType | input | 2 | Parity kind |
| cfgExtraEn | input | 1 | Extra bit present |
| cfgLongStop | input | 1 | Long stop field |
| cfgMultiProc | input | 1 | Multiprocessor address filtering |
| rxData | output | 8 | Last completed data, right-aligned |
| rxExtra | output | 1 | Extra bit of last completed frame |
| parityErr | output | 1 | Parity mismatch in last frame |
| frameErr | output | 1 | Low stop bit in last frame |
| rxDone | output | 1 | One-cycle completion pulse |

## Verification
The hardest condition to reach is a falling edge that lands inside the unchecked half stop bit of a five-bit, long-stop frame. A missing guard there is invisible unless the false start goes on to produce a frame. To expose it, the stimulus holds the line low from a few clocks into the half bit until well past the time a whole frame would last. A receiver without the guard then samples low stop bits and raises the framing flag, while a correct one stays silent. A start glitch shorter than half a bit and address frames with the extra bit low are driven in the same way, and the expected result in each case is an output that does not change.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  localparam int DATA_W  = 8;
  localparam int IDX_W   = $clog2(DATA_W);
  localparam int MIN_LEN = 5;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_EXTRA, ST_PARITY, ST_STOP1, ST_STOP2, ST_HOLD
  } rxPhase_t;

  typedef enum logic [1:0] {
    PAR_ODD   = 2'b00,
    PAR_EVEN  = 2'b01,
    PAR_MARK  = 2'b10,
    PAR_SPACE = 2'b11
  } parKind_t;

  // strobes from sequencer to datapath, valid for one clock
  typedef struct packed {
    logic             clear;
    logic             takeData;
    logic [IDX_W-1:0] dataIdx;
    logic             takeExtra;
    logic             takePar;
    logic             takeStop;
    logic             finish;
  } rxStrobe_t;

endpackage

// File: rtl/uart_rx_ctrl.sv
module uart_rx_ctrl
  import uart_rx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       rxSync,
  input  logic       rxFall,
  input  logic [1:0] cfgLen,
  input  logic       cfgParEn,
  input  logic       cfgExtraEn,
  input  logic       cfgLongStop,
  output rxStrobe_t  strb
);

  localparam int CNT_W = $clog2(OVS);
  localparam logic [CNT_W-1:0] MID_CNT = CNT_W'(OVS / 2 - 1);
  localparam logic [CNT_W-1:0] END_CNT = CNT_W'(OVS - 1);

  rxPhase_t         state, nState;
  logic [CNT_W-1:0] cnt, nCnt;
  logic [IDX_W-1:0] bitIdx, nIdx;
  logic [IDX_W-1:0] lastIdx;
  logic [CNT_W-1:0] cntInc;
  rxPhase_t         afterData;
  rxPhase_t         afterExtra;

  assign lastIdx    = IDX_W'(MIN_LEN - 1) + IDX_W'(cfgLen);
  assign cntInc     = (cnt == END_CNT) ? '0 : cnt + 1'b1;
  assign afterExtra = cfgParEn ? ST_PARITY : ST_STOP1;
  assign afterData  = cfgExtraEn ? ST_EXTRA : afterExtra;

  always_comb begin
    nState = state;
    nCnt   = cnt;
    nIdx   = bitIdx;
    strb   = '0;
    strb.dataIdx = bitIdx;
    case (state)
      ST_IDLE: begin
        if (rxFall) begin
          nState     = ST_START;
          nCnt       = '0;
          strb.clear = 1'b1;
        end
      end
      ST_START: begin
        if (tick) begin
          if (cnt == MID_CNT) begin
            nCnt   = '0;
            nIdx   = '0;
            nState = rxSync ? ST_IDLE : ST_DATA;
          end else begin
            nCnt = cnt + 1'b1;
          end
        end
      end
      ST_HOLD: begin
        if (tick) begin
          nCnt = cntInc;
          if (cnt == END_CNT) nState = ST_IDLE;
        end
      end
      default: begin
        if (tick) begin
          nCnt = cntInc;
          if (cnt == END_CNT) begin
            case (state)
              ST_DATA: begin
                strb.takeData = 1'b1;
                if (bitIdx == lastIdx) nState = afterData;
                else nIdx = bitIdx + 1'b1;
              end
              ST_EXTRA: begin
                strb.takeExtra = 1'b1;
                nState = afterExtra;
              end
              ST_PARITY: begin
                strb.takePar = 1'b1;
                nState = ST_STOP1;
              end
              ST_STOP1: begin
                strb.takeStop = 1'b1;
                if (cfgLongStop && cfgLen != 2'b00) begin
                  nState = ST_STOP2;
                end else begin
                  strb.finish = 1'b1;
                  nState = cfgLongStop ? ST_HOLD : ST_IDLE;
                end
              end
              default: begin
                strb.takeStop = 1'b1;
                strb.finish   = 1'b1;
                nState        = ST_IDLE;
              end
            endcase
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      bitIdx <= '0;
    end else begin
      state  <= nState;
      cnt    <= nCnt;
      bitIdx <= nIdx;
    end
  end

  // R1
  start_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |-> !rxSync);

  // R5
  hold_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HOLD) |=> (state == ST_HOLD || state == ST_IDLE));

endmodule

// File: rtl/uart_rx_dpath.sv
module uart_rx_dpath
  import uart_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxIn,
  input  logic              cfgParEn,
  input  logic [1:0]        cfgParType,
  input  logic              cfgMultiProc,
  input  rxStrobe_t         strb,
  output logic              rxSync,
  output logic              rxFall,
  output logic [DATA_W-1:0] rxData,
  output logic              rxExtra,
  output logic              parityErr,
  output logic              frameErr,
  output logic              rxDone
);

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   rxLast;
  logic [DATA_W-1:0]      shData;
  logic                   extraBit;
  logic                   parBit;
  logic                   stopBad;
  logic                   expPar;
  logic                   stopBadNow;
  logic                   mpBlock;
  logic                   frameOk;
  logic                   parErrNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncChain <= '1;
      rxLast    <= 1'b1;
    end else begin
      syncChain <= {syncChain[SYNC_STAGES-2:0], rxIn};
      rxLast    <= rxSync;
    end
  end

  assign rxSync = syncChain[SYNC_STAGES-1];
  assign rxFall = rxLast & ~rxSync;

  always_comb begin
    case (parKind_t'(cfgParType))
      PAR_ODD:  expPar = ~(^shData);
      PAR_EVEN: expPar = ^shData;
      PAR_MARK: expPar = 1'b1;
      default:  expPar = 1'b0;
    endcase
  end

  assign stopBadNow = stopBad | (strb.takeStop & ~rxSync);
  assign mpBlock    = cfgMultiProc & ~cfgParEn & ~extraBit;
  assign frameOk    = ~stopBadNow & ~mpBlock;
  assign parErrNow  = cfgParEn & (parBit != expPar);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shData   <= '0;
      extraBit <= 1'b0;
      parBit   <= 1'b0;
      stopBad  <= 1'b0;
    end else if (strb.clear) begin
      shData   <= '0;
      extraBit <= 1'b0;
      parBit   <= 1'b0;
      stopBad  <= 1'b0;
    end else begin
      if (strb.takeData)  shData[strb.dataIdx] <= rxSync;
      if (strb.takeExtra) extraBit <= rxSync;
      if (strb.takePar)   parBit   <= rxSync;
      if (strb.takeStop)  stopBad  <= stopBadNow;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData    <= '0;
      rxExtra   <= 1'b0;
      parityErr <= 1'b0;
      frameErr  <= 1'b0;
      rxDone    <= 1'b0;
    end else begin
      rxDone <= 1'b0;
      if (strb.finish) begin
        frameErr  <= stopBadNow;
        parityErr <= parErrNow;
        rxDone    <= frameOk;
        if (frameOk) begin
          rxData  <= shData;
          rxExtra <= extraBit;
        end
      end
    end
  end

  // R6
  done_no_ferr_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxDone |-> !frameErr);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxDone |=> !rxDone);

  // R7
  mp_extra_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxDone && $past(cfgMultiProc) && !$past(cfgParEn)) |-> rxExtra);

  // R4
  par_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.finish && !cfgParEn) |=> !parityErr);

endmodule

// File: rtl/uart_frame_rx.sv
module uart_frame_rx
  import uart_rx_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       rxIn,
  input  logic [1:0] cfgLen,
  input  logic       cfgParEn,
  input  logic [1:0] cfgParType,
  input  logic       cfgExtraEn,
  input  logic       cfgLongStop,
  input  logic       cfgMultiProc,
  output logic [7:0] rxData,
  output logic       rxExtra,
  output logic       parityErr,
  output logic       frameErr,
  output logic       rxDone
);

  rxStrobe_t strb;
  logic      rxSync;
  logic      rxFall;

  uart_rx_ctrl #(.OVS(OVS)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .tick        (tick),
    .rxSync      (rxSync),
    .rxFall      (rxFall),
    .cfgLen      (cfgLen),
    .cfgParEn    (cfgParEn),
    .cfgExtraEn  (cfgExtraEn),
    .cfgLongStop (cfgLongStop),
    .strb        (strb)
  );

  uart_rx_dpath #(.SYNC_STAGES(SYNC_STAGES)) u_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .rxIn         (rxIn),
    .cfgParEn     (cfgParEn),
    .cfgParType   (cfgParType),
    .cfgMultiProc (cfgMultiProc),
    .strb         (strb),
    .rxSync       (rxSync),
    .rxFall       (rxFall),
    .rxData       (rxData),
    .rxExtra      (rxExtra),
    .parityErr    (parityErr),
    .frameErr     (frameErr),
    .rxDone       (rxDone)
  );

  // R2
  short_zero_ext_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxDone && $past(cfgLen) == 2'b00) |-> (rxData[7:5] == 3'b000));

endmodule

// File: tb/uart_frame_rx_bench.sv
module uart_frame_rx_bench;
  timeunit 1ns;
  timeprecision 100ps;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick = 1'b0;
  logic       rxIn = 1'b1;
  logic [1:0] cfgLen = 2'b11;
  logic       cfgParEn = 1'b0;
  logic [1:0] cfgParType = 2'b00;
  logic       cfgExtraEn = 1'b0;
  logic       cfgLongStop = 1'b0;
  logic       cfgMultiProc = 1'b0;
  logic [7:0] rxData;
  logic       rxExtra, parityErr, frameErr, rxDone;

  uart_frame_rx u_uart_frame_rx (
    .clk(clk), .rstN(rstN), .tick(tick), .rxIn(rxIn),
    .cfgLen(cfgLen), .cfgParEn(cfgParEn), .cfgParType(cfgParType),
    .cfgExtraEn(cfgExtraEn), .cfgLongStop(cfgLongStop), .cfgMultiProc(cfgMultiProc),
    .rxData(rxData), .rxExtra(rxExtra), .parityErr(parityErr),
    .frameErr(frameErr), .rxDone(rxDone)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    int       at;
    bit       done;
    bit [7:0] data;
    bit       extra;
    bit       perr;
    bit       ferr;
  } expEvent_t;

  int        cyc = 0;
  int        testsRun = 0;
  int        failCnt = 0;
  bit        lineQ[$];
  expEvent_t evQ[$];
  bit        mDone = 0, mExtra = 0, mPerr = 0, mFerr = 0;
  bit [7:0]  mData = 0;
  string     curReq = "R10";
  bit        checking = 0;
  bit        finished = 0;

  // reference model stepped once per clock, compared against ports
  always @(negedge clk) begin
    expEvent_t ev;
    mDone = 0;
    if (evQ.size() > 0 && evQ[0].at == cyc - 1) begin
      ev = evQ.pop_front();
      mDone = ev.done;
      mPerr = ev.perr;
      mFerr = ev.ferr;
      if (ev.done) begin
        mData  = ev.data;
        mExtra = ev.extra;
      end
    end
    if (checking && !finished) begin
      testsRun++;
      if (rxDone !== mDone || rxData !== mData || rxExtra !== mExtra ||
          parityErr !== mPerr || frameErr !== mFerr) begin
        failCnt++;
        $display("FAIL %s cycle %0d: actual done=%b data=%h extra=%b perr=%b ferr=%b expected done=%b data=%h extra=%b perr=%b ferr=%b",
                 curReq, cyc - 1, rxDone, rxData, rxExtra, parityErr, frameErr,
                 mDone, mData, mExtra, mPerr, mFerr);
      end
    end
    rxIn = (lineQ.size() > 0) ? lineQ.pop_front() : 1'b1;
    tick = (cyc % 4 == 0);
    cyc++;
  end

  task automatic pushLevel(input bit v, input int n);
    for (int i = 0; i < n; i++) lineQ.push_back(v);
  endtask

  task automatic alignStart(output int s);
    int base;
    pushLevel(1'b1, 8);
    base = cyc + lineQ.size();
    while (base % 4 != 1) begin
      lineQ.push_back(1'b1);
      base++;
    end
    s = base;
  endtask

  task automatic sendFrame(input bit [1:0] len, input bit pe, input bit [1:0] pt,
                           input bit xe, input bit mp, input bit ls,
                           input bit [7:0] d, input bit xb, input bit badPar,
                           input bit st1, input bit st2, input bit holdPoke,
                           input string req);
    int s, nd, nb, ones, lastSample;
    bit [7:0] dm;
    bit pbit, stopBad, xbEff;
    expEvent_t ev;
    @(posedge clk); #1;
    cfgLen = len; cfgParEn = pe; cfgParType = pt; cfgExtraEn = xe;
    cfgMultiProc = mp; cfgLongStop = ls; curReq = req;
    alignStart(s);
    nd = 5 + int'(len);
    dm = d & 8'((1 << nd) - 1);
    pushLevel(1'b0, 64);
    for (int i = 0; i < nd; i++) pushLevel(dm[i], 64);
    nb = nd;
    if (xe) begin pushLevel(xb, 64); nb++; end
    ones = $countones(dm);
    case (pt)
      2'b00: pbit = (ones % 2 == 0);
      2'b01: pbit = (ones % 2 == 1);
      2'b10: pbit = 1'b1;
      default: pbit = 1'b0;
    endcase
    if (pe) begin pushLevel(pbit ^ badPar, 64); nb++; end
    pushLevel(st1, 64);
    nb++;
    if (ls && len != 2'b00) begin
      pushLevel(st2, 64);
      nb++;
    end else if (ls) begin
      if (holdPoke) begin
        pushLevel(1'b1, 8);
        pushLevel(1'b0, 1400);
      end else begin
        pushLevel(1'b1, 32);
      end
    end
    lastSample = s + 31 + 64 * nb;
    stopBad = !st1 || (ls && len != 2'b00 && !st2);
    xbEff   = xe ? xb : 1'b0;
    ev.at    = lastSample;
    ev.ferr  = stopBad;
    ev.perr  = pe && badPar;
    ev.done  = !stopBad && !(mp && !pe && !xbEff);
    ev.data  = dm;
    ev.extra = xbEff;
    evQ.push_back(ev);
    while (lineQ.size() > 0 || cyc < lastSample + 80) @(posedge clk);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    // R10: reset values
    testsRun++;
    if (rxData !== 8'h00 || rxExtra !== 1'b0 || parityErr !== 1'b0 ||
        frameErr !== 1'b0 || rxDone !== 1'b0) begin
      failCnt++;
      $display("FAIL R10 reset: actual data=%h extra=%b perr=%b ferr=%b done=%b expected all zero",
               rxData, rxExtra, parityErr, frameErr, rxDone);
    end
    checking = 1;
    // R2: lengths, LSB first, right aligned
    sendFrame(2'b11, 0, 2'b00, 0, 0, 0, 8'hA5, 0, 0, 1, 1, 0, "R2");
    sendFrame(2'b00, 0, 2'b00, 0, 0, 0, 8'hF5, 0, 0, 1, 1, 0, "R2");
    sendFrame(2'b01, 0, 2'b00, 0, 0, 0, 8'hEA, 0, 0, 1, 1, 0, "R2");
    sendFrame(2'b10, 0, 2'b00, 0, 0, 0, 8'h3C, 0, 0, 1, 1, 0, "R2");
    // R3: extra bit with and without parity
    sendFrame(2'b10, 0, 2'b00, 1, 0, 0, 8'h55, 1, 0, 1, 1, 0, "R3");
    sendFrame(2'b11, 1, 2'b01, 1, 0, 0, 8'h81, 1, 0, 1, 1, 0, "R3");
    // R4: parity kinds, good and bad
    sendFrame(2'b11, 1, 2'b00, 0, 0, 0, 8'h07, 0, 0, 1, 1, 0, "R4");
    sendFrame(2'b11, 1, 2'b00, 0, 0, 0, 8'h07, 0, 1, 1, 1, 0, "R4");
    sendFrame(2'b01, 1, 2'b01, 0, 0, 0, 8'h2B, 0, 1, 1, 1, 0, "R4");
    sendFrame(2'b11, 1, 2'b10, 0, 0, 0, 8'h10, 0, 1, 1, 1, 0, "R4");
    sendFrame(2'b11, 1, 2'b11, 0, 0, 0, 8'h11, 0, 0, 1, 1, 0, "R4");
    // R9: flag clears on next frame without parity
    sendFrame(2'b11, 0, 2'b11, 0, 0, 0, 8'h22, 0, 0, 1, 1, 0, "R9");
    // R6: low stop bit
    sendFrame(2'b11, 0, 2'b00, 0, 0, 0, 8'h99, 0, 0, 0, 1, 0, "R6");
    // R5: long stop, second stop checked
    sendFrame(2'b10, 0, 2'b00, 0, 0, 1, 8'h4E, 0, 0, 1, 0, 0, "R5");
    sendFrame(2'b10, 0, 2'b00, 0, 0, 1, 8'h4E, 0, 0, 1, 1, 0, "R5");
    // R5: 1.5 stop, low line during the half bit is ignored
    sendFrame(2'b00, 0, 2'b00, 0, 0, 1, 8'h0B, 0, 0, 1, 1, 1, "R5");
    sendFrame(2'b00, 0, 2'b00, 0, 0, 1, 8'h16, 0, 0, 1, 1, 0, "R5");
    // R1: short start glitch rejected
    begin
      int s;
      @(posedge clk); #1;
      curReq = "R1";
      alignStart(s);
      pushLevel(1'b0, 20);
      while (lineQ.size() > 0 || cyc < s + 120) @(posedge clk);
    end
    sendFrame(2'b11, 0, 2'b00, 0, 0, 0, 8'h6D, 0, 0, 1, 1, 0, "R1");
    // R7: multiprocessor filtering
    sendFrame(2'b11, 0, 2'b00, 1, 1, 0, 8'h42, 0, 0, 1, 1, 0, "R7");
    sendFrame(2'b11, 0, 2'b00, 1, 1, 0, 8'h43, 1, 0, 1, 1, 0, "R7");
    sendFrame(2'b11, 0, 2'b00, 0, 1, 0, 8'h44, 1, 0, 1, 1, 0, "R7");
    // R8: parity overrides filtering
    sendFrame(2'b11, 1, 2'b01, 1, 1, 0, 8'h45, 0, 0, 1, 1, 0, "R8");
    repeat (10) @(posedge clk);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, failCnt);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      finished = 1;
      failCnt++;
      $display("FAIL %s watchdog: actual hung expected finished", curReq);
      $display("[TB] %0d tests run, %0d failed", testsRun, failCnt);
      $finish;
    end
  end

endmodule